// File: doc/BRIEF.md
# Soft-Start and Hiccup Fault Sequencer

This block sequences start-up and fault recovery for a pair of regulated outputs. It watches a debounced bias-good flag, one undervoltage flag per output and an external shutdown request. From these it produces a shared soft-start reference code, one enable per output and a status code. The reference code is meant for a DAC or a digital PWM stage. Both outputs follow the same ramp, so they rise together and they are always switched on or off as a pair.

When bias becomes good, the code climbs from zero to full scale in a fixed number of clock cycles and then holds at full scale. Undervoltage flags are not looked at during the first part of each ramp. Once the code passes a programmable mask level, or once the block is regulating, an undervoltage on either output turns both outputs off. The block then waits for a number of silent soft-start periods before it tries a fresh ramp. If the fault is still present, this cycle repeats for as long as it lasts (hiccup). The shutdown request and the loss of bias both override this recovery sequence.

Top module: `softStartSeq`

## Requirements
- R1: After reset, and on any clock edge where biasOk is low, the block is idle: seqStatus = 0, rampCode = 0, every outEn bit is low.
- R2: On the first edge where biasOk is high, shdnReq is low and the state is idle, the block enters ramping (seqStatus = 1) with rampCode = 0 and every outEn bit high. rampCode then rises by one every STEP_CYCLES = SS_CYCLES / 2^CODE_W edges and never decreases while ramping. All outEn bits are always equal.
- R3: At the edge where the code would pass 2^CODE_W-2 on its final step, the block enters regulating (seqStatus = 2). In that state rampCode holds at full scale 2^CODE_W-1. So regulating begins (2^CODE_W-1)*STEP_CYCLES edges after the ramp begins.
- R4: While ramping with rampCode below MASK_CODE, undervoltage flags are ignored: the ramp continues unchanged.
- R5: An undervoltage on any output causes fault-blanking (seqStatus = 3) at the next edge, with rampCode = 0 and every outEn bit low. This applies while ramping with rampCode at or above MASK_CODE, and while regulating.
- R6: Fault-blanking lasts exactly RETRY_CYCLES*2^CODE_W*STEP_CYCLES edges, with outputs off and rampCode = 0 throughout. A new ramp then starts from code 0.
- R7: If the undervoltage persists, the fault–blank–retry sequence repeats without limit.
- R8: With biasOk high, shdnReq high causes shutdown (seqStatus = 4, rampCode = 0, outEn low) at the next edge. This holds from any state, including ramping and fault-blanking, and it discards any pending retry progress.
- R9: Releasing shdnReq starts a fresh ramp from code 0 at the next edge, without serving any remaining blanking delay.
- R10: biasOk low overrides shdnReq and any fault state: the block returns to idle at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| biasOk | input | 1 | Debounced bias-good flag |
| uvFlag | input | NUM_OUT | Undervoltage flag per output |
| shdnReq | input | 1 | External shutdown request, active high |
| rampCode | output | CODE_W | Shared soft-start reference code |
| outEn | output | NUM_OUT | Enable per output |
| seqStatus | output | 3 | 0 idle, 1 ramping, 2 regulating, 3 fault-blanking, 4 shutdown |

## Verification
The bench samples the code one cycle before and one cycle after the mask boundary. An off-by-one in the mask compare would fault one step early, or would let a step through that should have faulted. It measures the blanking interval to the exact edge. A design that counts two or four silent periods, or that restarts the retry count on each period, retries at the wrong edge. It asserts shutdown in the middle of blanking and checks that the release ramps at once; a design that kept the retry state would stay dark. It drops bias while shutdown is held, which shows whether the design got the priority between the two backwards.

// File: rtl/ssSeqPkg.sv
package ssSeqPkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RAMP  = 3'd1,
    ST_REG   = 3'd2,
    ST_BLANK = 3'd3,
    ST_SHDN  = 3'd4
  } seqState_t;

  // control -> datapath
  typedef struct packed {
    logic clrCount;
    logic clrRetry;
    logic advance;
    logic incRetry;
  } seqStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic stepEnd;
    logic nearTop;
    logic cycleEnd;
    logic monActive;
    logic retryLast;
  } seqFlags_t;

endpackage

// File: rtl/ssSeqDatapath.sv
module ssSeqDatapath
  import ssSeqPkg::*;
#(
  parameter int CODE_W       = 8,
  parameter int STEP_CYCLES  = 1335,
  parameter int MASK_CODE    = 65,
  parameter int RETRY_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  output seqFlags_t         flags,
  output logic [CODE_W-1:0] rampCnt
);

  localparam int STEP_W  = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam int RETRY_W = (RETRY_CYCLES > 1) ? $clog2(RETRY_CYCLES) : 1;
  localparam logic [STEP_W-1:0]  STEP_LAST  = STEP_W'(STEP_CYCLES - 1);
  localparam logic [RETRY_W-1:0] RETRY_LAST = RETRY_W'(RETRY_CYCLES - 1);
  localparam logic [CODE_W-1:0]  CODE_TOP   = '1;
  localparam logic [CODE_W-1:0]  CODE_PEN   = CODE_W'((2 ** CODE_W) - 2);
  localparam logic [CODE_W-1:0]  CODE_MASK  = CODE_W'(MASK_CODE);

  logic [STEP_W-1:0]  stepCnt;
  logic [RETRY_W-1:0] retryCnt;
  logic               stepWrap;

  assign stepWrap = (stepCnt == STEP_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepCnt <= '0;
      rampCnt <= '0;
    end else if (strobe.clrCount) begin
      stepCnt <= '0;
      rampCnt <= '0;
    end else if (strobe.advance) begin
      if (stepWrap) begin
        stepCnt <= '0;
        rampCnt <= rampCnt + 1'b1;
      end else begin
        stepCnt <= stepCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      retryCnt <= '0;
    end else if (strobe.clrRetry) begin
      retryCnt <= '0;
    end else if (strobe.incRetry) begin
      retryCnt <= retryCnt + 1'b1;
    end
  end

  always_comb begin
    flags.stepEnd   = stepWrap;
    flags.nearTop   = (rampCnt == CODE_PEN);
    flags.cycleEnd  = (rampCnt == CODE_TOP) && stepWrap;
    flags.monActive = (rampCnt >= CODE_MASK);
    flags.retryLast = (retryCnt == RETRY_LAST);
  end

endmodule

// File: rtl/ssSeqCtrl.sv
module ssSeqCtrl
  import ssSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       biasOk,
  input  logic       shdnReq,
  input  logic       uvAny,
  input  seqFlags_t  flags,
  output seqState_t  state,
  output seqStrobe_t strobe
);

  seqState_t nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    if (!biasOk) begin
      nextState       = ST_IDLE;
      strobe.clrCount = 1'b1;
      strobe.clrRetry = 1'b1;
    end else if (shdnReq) begin
      nextState       = ST_SHDN;
      strobe.clrCount = 1'b1;
      strobe.clrRetry = 1'b1;
    end else begin
      case (state)
        ST_IDLE, ST_SHDN: begin
          nextState       = ST_RAMP;
          strobe.clrCount = 1'b1;
          strobe.clrRetry = 1'b1;
        end
        ST_RAMP: begin
          if (uvAny && flags.monActive) begin
            nextState       = ST_BLANK;
            strobe.clrCount = 1'b1;
            strobe.clrRetry = 1'b1;
          end else begin
            strobe.advance = 1'b1;
            if (flags.stepEnd && flags.nearTop) nextState = ST_REG;
          end
        end
        ST_REG: begin
          if (uvAny) begin
            nextState       = ST_BLANK;
            strobe.clrCount = 1'b1;
            strobe.clrRetry = 1'b1;
          end
        end
        ST_BLANK: begin
          strobe.advance = 1'b1;
          if (flags.cycleEnd) begin
            if (flags.retryLast) begin
              nextState       = ST_RAMP;
              strobe.clrRetry = 1'b1;
            end else begin
              strobe.incRetry = 1'b1;
            end
          end
        end
        default: begin
          nextState       = ST_IDLE;
          strobe.clrCount = 1'b1;
          strobe.clrRetry = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

endmodule

// File: rtl/softStartSeq.sv
module softStartSeq
  import ssSeqPkg::*;
#(
  parameter int NUM_OUT      = 2,
  parameter int CODE_W       = 8,
  parameter int SS_CYCLES    = 342000,
  parameter int MASK_CODE    = 65,
  parameter int RETRY_CYCLES = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               biasOk,
  input  logic [NUM_OUT-1:0] uvFlag,
  input  logic               shdnReq,
  output logic [CODE_W-1:0]  rampCode,
  output logic [NUM_OUT-1:0] outEn,
  output logic [2:0]         seqStatus
);

  localparam int STEP_CYCLES = SS_CYCLES / (2 ** CODE_W);

  seqState_t         state;
  seqStrobe_t        strobe;
  seqFlags_t         flags;
  logic [CODE_W-1:0] rampCnt;
  logic              driving;

  ssSeqCtrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .biasOk  (biasOk),
    .shdnReq (shdnReq),
    .uvAny   (|uvFlag),
    .flags   (flags),
    .state   (state),
    .strobe  (strobe)
  );

  ssSeqDatapath #(
    .CODE_W       (CODE_W),
    .STEP_CYCLES  (STEP_CYCLES),
    .MASK_CODE    (MASK_CODE),
    .RETRY_CYCLES (RETRY_CYCLES)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .flags   (flags),
    .rampCnt (rampCnt)
  );

  assign driving   = (state == ST_RAMP) || (state == ST_REG);
  assign rampCode  = driving ? rampCnt : '0;
  assign seqStatus = state;

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_en
    assign outEn[g] = driving;
  end

endmodule

// File: rtl/ssSeqChecker.sv
module ssSeqChecker #(
  parameter int NUM_OUT   = 2,
  parameter int CODE_W    = 8,
  parameter int MASK_CODE = 65
) (
  input logic               clk,
  input logic               rstN,
  input logic               biasOk,
  input logic [NUM_OUT-1:0] uvFlag,
  input logic               shdnReq,
  input logic [CODE_W-1:0]  rampCode,
  input logic [NUM_OUT-1:0] outEn,
  input logic [2:0]         seqStatus
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    seqStatus == 3'd0 |-> (outEn == '0) && (rampCode == '0)); // R1

  AST_EN_PAIRED: assert property (@(posedge clk) disable iff (!rstN)
    (outEn == '0) || (outEn == '1)); // R2

  AST_RAMP_RISING: assert property (@(posedge clk) disable iff (!rstN)
    seqStatus == 3'd1 |=> (seqStatus != 3'd1) || (rampCode >= $past(rampCode))); // R2

  AST_REG_FULL: assert property (@(posedge clk) disable iff (!rstN)
    seqStatus == 3'd2 |-> rampCode == '1); // R3

  AST_UV_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (seqStatus == 3'd1) && (rampCode < CODE_W'(MASK_CODE)) && biasOk && !shdnReq
      |=> seqStatus != 3'd3); // R4

  AST_UV_IN_REG: assert property (@(posedge clk) disable iff (!rstN)
    (seqStatus == 3'd2) && (|uvFlag) && biasOk && !shdnReq |=> seqStatus == 3'd3); // R5

  AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rstN)
    seqStatus == 3'd3 |-> (outEn == '0) && (rampCode == '0)); // R6

  AST_SHDN_WINS: assert property (@(posedge clk) disable iff (!rstN)
    biasOk && shdnReq |=> seqStatus == 3'd4); // R8

  AST_BIAS_LOSS: assert property (@(posedge clk) disable iff (!rstN)
    !biasOk |=> seqStatus == 3'd0); // R10

endmodule

bind softStartSeq ssSeqChecker #(
  .NUM_OUT   (NUM_OUT),
  .CODE_W    (CODE_W),
  .MASK_CODE (MASK_CODE)
) i_ssSeqChecker (
  .clk       (clk),
  .rstN      (rstN),
  .biasOk    (biasOk),
  .uvFlag    (uvFlag),
  .shdnReq   (shdnReq),
  .rampCode  (rampCode),
  .outEn     (outEn),
  .seqStatus (seqStatus)
);

// File: tb/test_softStartSeq.sv
module test_softStartSeq;

  localparam int NUM_OUT = 2;
  localparam int CODE_W  = 4;   // full scale 15
  localparam int SS_CYC  = 48;  // 3 cycles per step
  localparam int MASK    = 4;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               biasOk = 1'b0;
  logic [NUM_OUT-1:0] uvFlag = '0;
  logic               shdnReq = 1'b0;
  logic [CODE_W-1:0]  rampCode;
  logic [NUM_OUT-1:0] outEn;
  logic [2:0]         seqStatus;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  softStartSeq #(
    .NUM_OUT      (NUM_OUT),
    .CODE_W       (CODE_W),
    .SS_CYCLES    (SS_CYC),
    .MASK_CODE    (MASK),
    .RETRY_CYCLES (3)
  ) i_softStartSeq (
    .clk       (clk),
    .rstN      (rstN),
    .biasOk    (biasOk),
    .uvFlag    (uvFlag),
    .shdnReq   (shdnReq),
    .rampCode  (rampCode),
    .outEn     (outEn),
    .seqStatus (seqStatus)
  );

  task automatic tickN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic checkOut(input string req, input int st, input int code, input int en);
    checkEq(req, "status", seqStatus, st);
    checkEq(req, "code", rampCode, code);
    checkEq(req, "enables", outEn, en);
  endtask

  task automatic testReset();
    tickN(3);
    rstN = 1'b1;
    tickN(1);
    checkOut("R1", 0, 0, 0);
    tickN(4);
    checkOut("R1", 0, 0, 0);
  endtask

  task automatic testRamp();
    biasOk = 1'b1;
    tickN(1);
    checkOut("R2", 1, 0, 3);
    tickN(3);
    checkOut("R2", 1, 1, 3);
    tickN(41);
    checkOut("R3", 1, 14, 3);
    tickN(1);
    checkOut("R3", 2, 15, 3);
    tickN(10);
    checkOut("R3", 2, 15, 3);
  endtask

  task automatic testUvReg();
    uvFlag = 2'b10;
    tickN(1);
    checkOut("R5", 3, 0, 0);
    uvFlag = 2'b00;
    tickN(70);
    checkOut("R6", 3, 0, 0);
    tickN(73);
    checkOut("R6", 3, 0, 0);
    tickN(1);
    checkOut("R6", 1, 0, 3);
    tickN(45);
    checkOut("R3", 2, 15, 3);
  endtask

  task automatic testMask();
    shdnReq = 1'b1;
    tickN(1);
    checkOut("R8", 4, 0, 0);
    shdnReq = 1'b0;
    tickN(1);
    checkOut("R9", 1, 0, 3);
    uvFlag = 2'b01;
    tickN(9);
    checkOut("R4", 1, 3, 3);
    tickN(3);
    checkOut("R4", 1, 4, 3);
    tickN(1);
    checkOut("R5", 3, 0, 0);
    tickN(144);
    checkOut("R7", 1, 0, 3);
    tickN(12);
    checkOut("R7", 1, 4, 3);
    tickN(1);
    checkOut("R7", 3, 0, 0);
  endtask

  task automatic testShdnBlank();
    uvFlag = 2'b00;
    tickN(20);
    shdnReq = 1'b1;
    tickN(1);
    checkOut("R8", 4, 0, 0);
    tickN(5);
    checkOut("R8", 4, 0, 0);
    shdnReq = 1'b0;
    tickN(1);
    checkOut("R9", 1, 0, 3);
    tickN(3);
    checkOut("R9", 1, 1, 3);
  endtask

  task automatic testBiasLoss();
    shdnReq = 1'b1;
    biasOk  = 1'b0;
    tickN(1);
    checkOut("R10", 0, 0, 0);
    biasOk = 1'b1;
    tickN(1);
    checkOut("R8", 4, 0, 0);
    shdnReq = 1'b0;
    tickN(1);
    checkOut("R2", 1, 0, 3);
    tickN(45);
    checkOut("R3", 2, 15, 3);
    biasOk = 1'b0;
    tickN(1);
    checkOut("R10", 0, 0, 0);
    tickN(3);
    checkOut("R1", 0, 0, 0);
  endtask

  initial begin
    testReset();
    testRamp();
    testUvReg();
    testMask();
    testShdnBlank();
    testBiasLoss();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule